// File: doc/BRIEF.md
# Dual-Clock FIFO With Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words that moves data from a write clock domain to an independent read clock domain. Words go in on rising edges of the write clock and come out, in the same order, on rising edges of the read clock. The depth is a parameter and defaults to 64 words. Four active-low flags report the fill level. Empty and almost-empty are produced in the read domain. Full and almost-full are produced in the write domain. Each pointer crosses to the other domain as Gray code through a two-flop synchronizer. Because of this, a flag may clear a few cycles late, but it never clears early.

A multi-purpose control input named `aux_ctl` is captured while reset is held, and its level fixes the operating mode until the next reset. With the input high, the block runs in dual-enable mode, where `aux_ctl` works as a second, active-high write enable. With the input low, the block runs in threshold-load mode. In that mode, driving `aux_ctl` low together with the write enable stores the low bits of the data bus into the two threshold registers instead of into the buffer. Both thresholds come out of reset at 7.

A read drives the registered output word. An active-low output enable produces a separate qualifier, and that qualifier stands in for a tri-state output bus.

Top module: `dcfifo_flagged`

## Requirements
- R1: While `rst` is high and after it is released with nothing written, `empty_n` and `aempty_n` are 0 and `full_n` and `afull_n` are 1.
- R2: A word is stored on a rising `wr_clk` edge when `wr_en_n` is 0, `aux_ctl` is 1 and `full_n` is 1. When the buffer holds DEPTH words, `full_n` is 0 and further write attempts are dropped.
- R3: The level of `aux_ctl` during reset selects the mode: 1 selects dual-enable mode and 0 selects threshold-load mode. The mode holds until the next reset.
- R4: In dual-enable mode, a cycle with `wr_en_n` 0 and `aux_ctl` 0 neither stores a word nor changes any threshold.
- R5: A word is read on a rising `rd_clk` edge only when `rd_en_a_n` and `rd_en_b_n` are both 0 and `empty_n` is 1. A read with only one enable low does nothing, and a read attempted while empty leaves `dout` unchanged.
- R6: Read data appears on `dout` after the `rd_clk` edge that performs the read, in the order the words were written.
- R7: With the reset thresholds of 7, `aempty_n` is 0 while the stored count is 7 or fewer, and `afull_n` is 0 while the count is DEPTH-7 or more.
- R8: In threshold-load mode, each write-clock edge with `wr_en_n` 0 and `aux_ctl` 0 loads `din[AW-1:0]` (AW = log2 DEPTH) into a threshold register and stores no data. The first load sets the almost-empty threshold, the second sets the almost-full threshold, and the order then wraps.
- R9: With loaded thresholds E and F, `aempty_n` is 0 while the count is E or fewer, and `afull_n` is 0 while the count is DEPTH-F or more.
- R10: `dout_valid` is 1 exactly when `oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| rd_clk | input | 1 | Read domain clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| aux_ctl | input | 1 | Mode select during reset; afterwards second write enable or threshold-load control |
| wr_en_n | input | 1 | Active-low write enable |
| din | input | 9 | Write data, or threshold value in its low AW bits |
| rd_en_a_n | input | 1 | First active-low read enable |
| rd_en_b_n | input | 1 | Second active-low read enable |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 9 | Registered read data |
| dout_valid | output | 1 | Output bus driven qualifier |
| empty_n | output | 1 | Low when empty (read domain) |
| aempty_n | output | 1 | Low at or below the almost-empty threshold (read domain) |
| afull_n | output | 1 | Low at or above DEPTH minus the almost-full threshold (write domain) |
| full_n | output | 1 | Low when full (write domain) |

## Verification
A corrupted pointer shows up at the ports as a word that is out of order, duplicated or missing. It appears on the first read that reaches the bad entry. A stuck or mis-compared flag appears as a threshold crossing that lands one word early or late. So the bench walks the count across each boundary one word at a time and lets the synchronizers settle before each sample. A wrong mode latch or a wrong threshold-select order appears as a flag that switches at the wrong count right after the loads. Dropped writes attempted while full would show up as extra words in the drained stream.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
    localparam int DATA_W     = 9;
    localparam int DEF_OFFSET = 7;

    typedef enum logic {
        MODE_LOAD = 1'b0,
        MODE_DUAL = 1'b1
    } fifo_mode_e;

    typedef struct packed {
        logic ae_sel;
        logic af_sel;
    } thr_sel_t;
endpackage

// File: rtl/dcfifo_sync2.sv
module dcfifo_sync2 #(
    parameter int          W    = 4,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= INIT;
            q    <= INIT;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcfifo_wside.sv
module dcfifo_wside
    import dcfifo_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              aux_ctl,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] din,
    input  logic [AW:0]       rgray_s,
    output logic              wfire,
    output logic [AW-1:0]     waddr,
    output logic [AW:0]       wgray,
    output logic              full_n,
    output logic              afull_n,
    output logic [AW-1:0]     ae_off
);
    localparam logic [AW:0]   DEPTH_C = (AW+1)'(1 << AW);
    localparam logic [AW-1:0] DEF_C   = AW'(DEF_OFFSET);

    fifo_mode_e    mode;
    thr_sel_t      sel;
    logic [AW:0]   wbin, wbin_nxt, rbin_s, count;
    logic [AW-1:0] af_off;
    logic          load;

    always_comb begin
        rbin_s[AW] = rgray_s[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
        end
    end

    assign count    = wbin - rbin_s;
    assign full_n   = (count != DEPTH_C);
    assign afull_n  = (count < (DEPTH_C - {1'b0, af_off}));
    assign wfire    = !wr_en_n && aux_ctl && full_n;
    assign load     = (mode == MODE_LOAD) && !wr_en_n && !aux_ctl;
    assign wbin_nxt = wbin + 1'b1;
    assign waddr    = wbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin   <= '0;
            wgray  <= '0;
            mode   <= aux_ctl ? MODE_DUAL : MODE_LOAD;
            sel    <= '{ae_sel: 1'b1, af_sel: 1'b0};
            ae_off <= DEF_C;
            af_off <= DEF_C;
        end else begin
            if (wfire) begin
                wbin  <= wbin_nxt;
                wgray <= wbin_nxt ^ (wbin_nxt >> 1);
            end
            if (load) begin
                if (sel.ae_sel) ae_off <= din[AW-1:0];
                if (sel.af_sel) af_off <= din[AW-1:0];
                sel <= '{ae_sel: sel.af_sel, af_sel: sel.ae_sel};
            end
        end
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        !full_n |=> $stable(wbin));
    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        count <= DEPTH_C);
    p_mode_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(mode));
    p_load_no_data_r8: assert property (@(posedge clk) disable iff (rst)
        load |=> $stable(wbin));
    p_sel_rotate_r8: assert property (@(posedge clk) disable iff (rst)
        load |=> (sel.ae_sel == $past(sel.af_sel)));
    p_sel_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel.ae_sel, sel.af_sel}) && (sel.ae_sel || sel.af_sel));
endmodule

// File: rtl/dcfifo_rside.sv
module dcfifo_rside
    import dcfifo_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en_a_n,
    input  logic              rd_en_b_n,
    input  logic [AW:0]       wgray_s,
    input  logic [AW-1:0]     ae_off_s,
    input  logic [DATA_W-1:0] mem_word,
    output logic [AW-1:0]     raddr,
    output logic [AW:0]       rgray,
    output logic [DATA_W-1:0] dout,
    output logic              empty_n,
    output logic              aempty_n
);
    logic [AW:0] rbin, rbin_nxt, wbin_s, count;
    logic        rfire;

    always_comb begin
        wbin_s[AW] = wgray_s[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
        end
    end

    assign count    = wbin_s - rbin;
    assign empty_n  = (count != '0);
    assign aempty_n = (count > {1'b0, ae_off_s});
    assign rfire    = !rd_en_a_n && !rd_en_b_n && empty_n;
    assign rbin_nxt = rbin + 1'b1;
    assign raddr    = rbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
            dout  <= '0;
        end else if (rfire) begin
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
            dout  <= mem_word;
        end
    end

    p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
        !empty_n |=> $stable(rbin) && $stable(dout));
    p_rd_step_r6: assert property (@(posedge clk) disable iff (rst)
        (rbin == $past(rbin)) || (rbin == $past(rbin) + 1'b1));
    p_gray_step_r6: assert property (@(posedge clk) disable iff (rst)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dcfifo_flagged.sv
module dcfifo_flagged
    import dcfifo_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              aux_ctl,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_en_a_n,
    input  logic              rd_en_b_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    output logic              empty_n,
    output logic              aempty_n,
    output logic              afull_n,
    output logic              full_n
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW:0]       wgray, wgray_s, rgray, rgray_s;
    logic [AW-1:0]     waddr, raddr, ae_off, ae_off_s;
    logic              wfire;

    dcfifo_wside #(.AW(AW)) u_wside (
        .clk(wr_clk), .rst(rst), .aux_ctl(aux_ctl), .wr_en_n(wr_en_n),
        .din(din), .rgray_s(rgray_s), .wfire(wfire), .waddr(waddr),
        .wgray(wgray), .full_n(full_n), .afull_n(afull_n), .ae_off(ae_off)
    );

    dcfifo_sync2 #(.W(AW+1)) u_w2r (
        .clk(rd_clk), .rst(rst), .d(wgray), .q(wgray_s)
    );

    dcfifo_sync2 #(.W(AW+1)) u_r2w (
        .clk(wr_clk), .rst(rst), .d(rgray), .q(rgray_s)
    );

    dcfifo_sync2 #(.W(AW), .INIT(AW'(DEF_OFFSET))) u_thr (
        .clk(rd_clk), .rst(rst), .d(ae_off), .q(ae_off_s)
    );

    dcfifo_rside #(.AW(AW)) u_rside (
        .clk(rd_clk), .rst(rst), .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n),
        .wgray_s(wgray_s), .ae_off_s(ae_off_s), .mem_word(mem[raddr]),
        .raddr(raddr), .rgray(rgray), .dout(dout), .empty_n(empty_n),
        .aempty_n(aempty_n)
    );

    always_ff @(posedge wr_clk) begin
        if (wfire) mem[waddr] <= din;
    end

    assign dout_valid = !oe_n;

    p_flag_order_r7: assert property (@(posedge wr_clk) disable iff (rst)
        !full_n |-> !afull_n);
    p_empty_implies_ae_r7: assert property (@(posedge rd_clk) disable iff (rst)
        !empty_n |-> !aempty_n);
endmodule

// File: tb/test_dcfifo_flagged.sv
module test_dcfifo_flagged;
    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = CLK_PERIOD * 3 / 2;
    localparam int DEPTH      = 64;

    logic       wr_clk = 0, rd_clk = 0, rst = 1, aux_ctl = 1, wr_en_n = 1;
    logic [8:0] din = '0;
    logic       rd_en_a_n = 1, rd_en_b_n = 1, oe_n = 1;
    logic [8:0] dout;
    logic       dout_valid, empty_n, aempty_n, afull_n, full_n;

    int         n_chk = 0, n_fail = 0;
    logic [8:0] sb[$];
    logic [8:0] last;

    always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

    dcfifo_flagged #(.DEPTH(DEPTH)) i_dcfifo_flagged (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .aux_ctl(aux_ctl),
        .wr_en_n(wr_en_n), .din(din), .rd_en_a_n(rd_en_a_n),
        .rd_en_b_n(rd_en_b_n), .oe_n(oe_n), .dout(dout),
        .dout_valid(dout_valid), .empty_n(empty_n), .aempty_n(aempty_n),
        .afull_n(afull_n), .full_n(full_n)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode_lvl);
        rst = 1; aux_ctl = mode_lvl; wr_en_n = 1; rd_en_a_n = 1; rd_en_b_n = 1;
        repeat (6) @(negedge wr_clk);
        rst = 0; aux_ctl = 1;
        sb.delete();
    endtask

    task automatic settle();
        #(CLK_PERIOD * 10);
    endtask

    task automatic wr_word(input logic [8:0] v, input bit accept);
        @(negedge wr_clk);
        wr_en_n = 0; aux_ctl = 1; din = v;
        if (accept) sb.push_back(v);
        @(negedge wr_clk);
        wr_en_n = 1;
    endtask

    task automatic wr_aux_low(input logic [8:0] v);
        @(negedge wr_clk);
        wr_en_n = 0; aux_ctl = 0; din = v;
        @(negedge wr_clk);
        wr_en_n = 1; aux_ctl = 1;
    endtask

    task automatic rd_words(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge rd_clk);
            rd_en_a_n = 0; rd_en_b_n = 0;
            @(negedge rd_clk);
            rd_en_a_n = 1; rd_en_b_n = 1;
        end
    endtask

    // Monitor: scoreboard pop on every qualified read (R6)
    always @(posedge rd_clk) begin
        if (!rst && !rd_en_a_n && !rd_en_b_n && empty_n) begin
            logic [8:0] exp_w;
            if (sb.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R6 read with empty scoreboard: actual 1 expected 0");
            end else begin
                exp_w = sb.pop_front();
                @(negedge rd_clk);
                check("R6", "read data", dout, exp_w);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // Dual-enable mode
        do_reset(1'b1);
        settle();
        check("R1", "empty_n", empty_n, 0);
        check("R1", "aempty_n", aempty_n, 0);
        check("R1", "full_n", full_n, 1);
        check("R1", "afull_n", afull_n, 1);
        #1 check("R10", "valid oe high", dout_valid, 0);
        oe_n = 0;
        #1 check("R10", "valid oe low", dout_valid, 1);

        for (int i = 0; i < 5; i++) wr_word(9'(i + 1), 1'b1);
        settle();
        check("R2", "empty_n after writes", empty_n, 1);
        check("R7", "aempty_n count5", aempty_n, 0);

        for (int i = 0; i < 3; i++) wr_aux_low(9'(200 + i));
        settle();
        check("R4", "aempty_n after aux-low writes", aempty_n, 0);

        for (int i = 0; i < 3; i++) wr_word(9'(i + 6), 1'b1);
        settle();
        check("R7", "aempty_n count8", aempty_n, 1);

        @(negedge rd_clk);
        rd_en_a_n = 0; rd_en_b_n = 1;
        repeat (4) @(negedge rd_clk);
        rd_en_a_n = 1;
        settle();
        check("R5", "aempty_n after single-enable read", aempty_n, 1);

        rd_words(8);
        settle();
        check("R5", "empty_n after drain", empty_n, 0);
        check("R6", "scoreboard drained", sb.size(), 0);
        last = dout;
        rd_words(3);
        settle();
        check("R5", "dout held on empty read", dout, last);
        check("R5", "empty_n stays", empty_n, 0);

        for (int i = 0; i < DEPTH - 8; i++) wr_word(9'(i + 100), 1'b1);
        settle();
        check("R7", "afull_n at DEPTH-8", afull_n, 1);
        wr_word(9'(300), 1'b1);
        settle();
        check("R7", "afull_n at DEPTH-7", afull_n, 0);
        for (int i = 0; i < 6; i++) wr_word(9'(310 + i), 1'b1);
        settle();
        check("R2", "full_n at DEPTH-1", full_n, 1);
        wr_word(9'(400), 1'b1);
        settle();
        check("R2", "full_n at DEPTH", full_n, 0);
        wr_word(9'(450), 1'b0);
        wr_word(9'(451), 1'b0);
        settle();
        rd_words(DEPTH);
        settle();
        check("R2", "empty after full drain", empty_n, 0);
        check("R2", "no extra words", sb.size(), 0);

        // Threshold-load mode
        do_reset(1'b0);
        settle();
        check("R1", "empty_n load mode", empty_n, 0);
        wr_aux_low(9'd3);
        wr_aux_low(9'd10);
        wr_aux_low(9'd1);
        settle();
        check("R8", "loads store no data", empty_n, 0);
        wr_word(9'd21, 1'b1);
        settle();
        check("R8", "aempty_n count1 thr1", aempty_n, 0);
        check("R3", "load mode data write", empty_n, 1);
        wr_word(9'd22, 1'b1);
        settle();
        check("R9", "aempty_n count2 thr1", aempty_n, 1);
        for (int i = 0; i < DEPTH - 10 - 3; i++) wr_word(9'(i + 30), 1'b1);
        settle();
        check("R9", "afull_n at DEPTH-11", afull_n, 1);
        wr_word(9'd99, 1'b1);
        settle();
        check("R9", "afull_n at DEPTH-10", afull_n, 0);
        rd_words(DEPTH - 10);
        settle();
        check("R6", "load-mode drain", sb.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule